// File: doc/BRIEF.md
# Dual-Timer ADC Event Sequencer

This block schedules ADC conversion strobes against two trigger timers that run on their own. Each timer owns eight events. An event has an enable bit and a 16-bit offset. When a timer's trigger is accepted, the timer counts sample-clock cycles from zero. Every enabled event of that timer is raised once, when the count equals its offset. Each raised event produces one active-low chip-select frame on a single shared line toward a serial-port ADC interface. The frame carries the global index of the event.

The chip-select is withheld for the first three sample clocks after the block is enabled, so the downstream port sees stable clocks before its first frame sync. Events that come due during that time, or while another frame is being sent, wait for their turn and are not lost. A status bit for each event records that its frame was sent. One shared completion flag rises when every enabled event of a triggered timer has been served. This holds even if the other timer was never triggered, so software that needs the full picture reads the status bits.

Top module: `adc_evt_seq`

## Requirements
- R1: After reset, and while `en` is low, `cs_n` is 1, `evt_status` is 0 and `done_flag` is 0.
- R2: No chip-select frame starts within the first 3 clocks after `en` is first sampled high. An event with offset 0, triggered in that same cycle, starts its frame 3 clocks after that edge.
- R3: With the block warmed up and idle, an event with offset T starts its frame (`cs_n` low) T+1 clocks after the edge that accepts its timer's trigger.
- R4: Each frame holds `cs_n` low for exactly CS_LEN clocks (default 16). `cs_evt` shows the event's global index, timer*8 + event, and stays steady during the frame. Frames are separated by at least one high clock.
- R5: Within a timer, frames follow ascending offset. When several events are due while the line is busy, or due together, the lowest global index is served first and the rest are delayed, not dropped.
- R6: `evt_status[i]` is set when the frame of event i ends. Writing 1 to bit i of `st_w1c` clears it. A set in the same cycle wins over the clear. A clear does not affect `done_flag`.
- R7: `done_flag` rises once every enabled event of a triggered timer has finished its frame, whether or not the other timer was triggered.
- R8: An accepted trigger of either timer clears `done_flag` and clears the status bits of that timer's eight events.
- R9: A trigger that arrives while its timer's schedule is still running is ignored and does not restart the count.
- R10: An event whose enable bit is 0 never produces a frame and never sets its status bit.
- R11: Dropping `en` ends any frame at the next edge, stops both timers, and clears the status bits and `done_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| trig | input | 2 | Trigger strobe for each timer, bit 0 = timer 0 |
| cfg_we | input | 1 | Write strobe for one event's configuration |
| cfg_idx | input | 4 | Global event index, timer*8 + event |
| cfg_time | input | 16 | Event offset in sample clocks after the trigger |
| cfg_ena | input | 1 | Event enable |
| st_w1c | input | 16 | Write-1-to-clear mask for the status bits |
| cs_n | output | 1 | Active-low chip-select |
| cs_evt | output | 4 | Global index of the event being served |
| evt_status | output | 16 | Per-event completion bits |
| done_flag | output | 1 | Shared completion flag |

## Verification
The assertions assume that `CS_LEN` is at least 2 and that event configuration is left alone while its timer runs. They also assume that triggers are level strobes sampled on each edge. The stimulus writes configuration only while both timers are idle. Random schedules place each event's offset in its own 24-clock slot with a small jitter, so frames never overlap unless a directed case creates the collision. Retriggers, triggers during warm-up and a disable in the middle of a frame are created only on purpose.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SEQ_TIMERS = 2;
  localparam int SEQ_EVTS   = 8;
  localparam int SEQ_TW     = 16;
  localparam int SEQ_CSLEN  = 16;
  localparam int SEQ_WARMUP = 3;

  typedef enum logic {TMR_IDLE = 1'b0, TMR_RUN = 1'b1} tmr_state_e;
endpackage

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int N_EVT = 8,
  parameter int TW    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       trig,
  input  logic [N_EVT-1:0]           ev_ena,
  input  logic [N_EVT-1:0][TW-1:0]   ev_time,
  input  logic [N_EVT-1:0]           served_set,
  output logic [N_EVT-1:0]           match_o,
  output logic                       accept_o,
  output logic                       finish_o
);
  import adc_seq_pkg::*;

  localparam logic [TW-1:0] CNT_MAX = '1;

  tmr_state_e        st_q, st_d;
  logic [TW-1:0]     cnt_q, cnt_d;
  logic [N_EVT-1:0]  hit_q, hit_d;
  logic [N_EVT-1:0]  srv_q, srv_d;
  logic              running;

  assign running  = (st_q == TMR_RUN);
  assign accept_o = en && trig && !running;
  assign finish_o = running && (&(srv_q | ~ev_ena));

  always_comb begin
    for (int e = 0; e < N_EVT; e++) begin
      match_o[e] = running && ev_ena[e] && !hit_q[e] && (cnt_q == ev_time[e]);
    end
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    hit_d = hit_q | match_o;
    srv_d = srv_q | served_set;
    if (!en) begin
      st_d  = TMR_IDLE;
      cnt_d = '0;
      hit_d = '0;
      srv_d = '0;
    end else if (accept_o) begin
      st_d  = TMR_RUN;
      cnt_d = '0;
      hit_d = '0;
      srv_d = '0;
    end else if (finish_o) begin
      st_d  = TMR_IDLE;
    end else if (running && cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TMR_IDLE;
      cnt_q <= '0;
      hit_q <= '0;
      srv_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      hit_q <= hit_d;
      srv_q <= srv_d;
    end
  end

  // R9: a trigger seen mid-schedule must not pull the count back to zero
  assert_retrig_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && running && trig && !finish_o) |=> (cnt_q != '0));

  // R7: a finished schedule leaves the timer idle
  assert_finish_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && finish_o) |=> (st_q == TMR_IDLE));
endmodule

// File: rtl/cs_arbiter.sv
module cs_arbiter #(
  parameter int N      = 16,
  parameter int CS_LEN = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 warm_ok,
  input  logic [N-1:0]         match,
  output logic                 cs_n,
  output logic [$clog2(N)-1:0] cs_idx,
  output logic [N-1:0]         done_vec
);
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(CS_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(CS_LEN - 1);

  logic [N-1:0]  pend_q, pend_d;
  logic          busy_q, busy_d;
  logic [CW-1:0] len_q, len_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [N-1:0]  req;
  logic [IW-1:0] pick;
  logic          grant, frame_end;

  assign req       = pend_q | match;
  assign frame_end = busy_q && (len_q == '0);
  assign grant     = en && !busy_q && warm_ok && (|req);

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) pick = IW'(i);
    end
  end

  always_comb begin
    done_vec = '0;
    if (frame_end) done_vec[idx_q] = 1'b1;
  end

  always_comb begin
    pend_d = req;
    busy_d = busy_q;
    len_d  = len_q;
    idx_d  = idx_q;
    if (!en) begin
      pend_d = '0;
      busy_d = 1'b0;
      len_d  = '0;
    end else if (grant) begin
      pend_d       = req;
      pend_d[pick] = 1'b0;
      busy_d       = 1'b1;
      len_d        = LOAD;
      idx_d        = pick;
    end else if (frame_end) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      len_d = len_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      busy_q <= 1'b0;
      len_q  <= '0;
      idx_q  <= '0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
      len_q  <= len_d;
      if (grant) idx_q <= idx_d;
    end
  end

  assign cs_n   = !busy_q;
  assign cs_idx = idx_q;

  // R2: a frame never opens before the warm-up has elapsed
  assert_grant_warm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(warm_ok));

  // R5: a frame opens only for an event that was due or waiting
  assert_grant_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(|req));

  // R4: a frame lasts longer than one clock and its index is steady
  assert_frame_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $rose(busy_q)) |=> (busy_q && $stable(idx_q)));
endmodule

// File: rtl/adc_evt_seq.sv
module adc_evt_seq
  import adc_seq_pkg::*;
#(
  parameter int N_TMR  = SEQ_TIMERS,
  parameter int N_EVT  = SEQ_EVTS,
  parameter int TW     = SEQ_TW,
  parameter int CS_LEN = SEQ_CSLEN,
  parameter int WARMUP = SEQ_WARMUP
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             en,
  input  logic [N_TMR-1:0]                 trig,
  input  logic                             cfg_we,
  input  logic [$clog2(N_TMR*N_EVT)-1:0]   cfg_idx,
  input  logic [TW-1:0]                    cfg_time,
  input  logic                             cfg_ena,
  input  logic [N_TMR*N_EVT-1:0]           st_w1c,
  output logic                             cs_n,
  output logic [$clog2(N_TMR*N_EVT)-1:0]   cs_evt,
  output logic [N_TMR*N_EVT-1:0]           evt_status,
  output logic                             done_flag
);
  localparam int NE = N_TMR * N_EVT;
  localparam int WW = $clog2(WARMUP + 1);
  localparam logic [WW-1:0] WARM_END = WW'(WARMUP);

  logic [NE-1:0][TW-1:0] ev_time_q;
  logic [NE-1:0]         ev_ena_q;
  logic [WW-1:0]         warm_q, warm_d;
  logic                  warm_ok;
  logic [NE-1:0]         match_all, done_vec, tmr_clr;
  logic [NE-1:0]         stat_q, stat_d;
  logic                  flag_q, flag_d;
  logic [N_TMR-1:0]      acc, fin;

  // event configuration store
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_time_q <= '0;
      ev_ena_q  <= '0;
    end else if (cfg_we) begin
      ev_time_q[cfg_idx] <= cfg_time;
      ev_ena_q[cfg_idx]  <= cfg_ena;
    end
  end

  // warm-up counter gating the first chip-select
  assign warm_ok = (warm_q == WARM_END);
  always_comb begin
    warm_d = warm_q;
    if (!en)          warm_d = '0;
    else if (!warm_ok) warm_d = warm_q + 1'b1;
  end

  genvar t;
  generate
    for (t = 0; t < N_TMR; t++) begin : g_tmr
      evt_timer #(.N_EVT(N_EVT), .TW(TW)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .trig       (trig[t]),
        .ev_ena     (ev_ena_q[t*N_EVT +: N_EVT]),
        .ev_time    (ev_time_q[t*N_EVT +: N_EVT]),
        .served_set (done_vec[t*N_EVT +: N_EVT]),
        .match_o    (match_all[t*N_EVT +: N_EVT]),
        .accept_o   (acc[t]),
        .finish_o   (fin[t])
      );
      assign tmr_clr[t*N_EVT +: N_EVT] = {N_EVT{acc[t]}};
    end
  endgenerate

  cs_arbiter #(.N(NE), .CS_LEN(CS_LEN)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .warm_ok  (warm_ok),
    .match    (match_all),
    .cs_n     (cs_n),
    .cs_idx   (cs_evt),
    .done_vec (done_vec)
  );

  // status bits and shared completion flag
  always_comb begin
    stat_d = ((stat_q & ~st_w1c) & ~tmr_clr) | done_vec;
    flag_d = flag_q;
    if (|acc)      flag_d = 1'b0;
    else if (|fin) flag_d = 1'b1;
    if (!en) begin
      stat_d = '0;
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
      stat_q <= '0;
      flag_q <= 1'b0;
    end else begin
      warm_q <= warm_d;
      stat_q <= stat_d;
      flag_q <= flag_d;
    end
  end

  assign evt_status = stat_q;
  assign done_flag  = flag_q;

  // R7: the flag only rises after some timer completed its schedule
  assert_flag_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(|fin));

  // R11: a disabled block is silent on the next edge
  assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cs_n && !done_flag && (evt_status == '0)));

  // R8: an accepted trigger leaves the flag low
  assert_trig_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && |acc) |=> !done_flag);
endmodule

// File: tb/adc_evt_seq_tb.sv
module adc_evt_seq_tb;
  localparam int CSL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  trig = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [15:0] cfg_time = '0;
  logic        cfg_ena = 1'b0;
  logic [15:0] st_w1c = '0;
  logic        cs_n;
  logic [3:0]  cs_evt;
  logic [15:0] evt_status;
  logic        done_flag;

  int n_tests = 0;
  int n_fail  = 0;
  int log_idx [0:31];
  int n_log = 0;
  bit prev_cs = 1'b1;
  int low_len = 0;

  always #4 clk = ~clk;

  adc_evt_seq u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .trig(trig),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_time(cfg_time), .cfg_ena(cfg_ena),
    .st_w1c(st_w1c), .cs_n(cs_n), .cs_evt(cs_evt),
    .evt_status(evt_status), .done_flag(done_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // frame monitor: logs indices, checks frame length (R4)
  initial begin
    forever begin
      @(negedge clk);
      if (!cs_n && prev_cs) begin
        if (n_log < 32) log_idx[n_log] = int'(cs_evt);
        n_log++;
        low_len = 1;
      end else if (!cs_n) begin
        low_len++;
      end else if (cs_n && !prev_cs && en) begin
        chk(low_len == CSL, "R4 frame length", low_len, CSL);
      end
      prev_cs = cs_n;
    end
  end

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic cfg(input int idx, input int tm, input bit ena);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_time = 16'(tm); cfg_ena = ena;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_clear_all();
    for (int i = 0; i < 16; i++) cfg(i, 0, 1'b0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pulse triggers; returns at the negedge after the accepting edge
  task automatic fire(input logic [1:0] m);
    @(negedge clk);
    trig = m;
    @(negedge clk);
    trig = '0;
  endtask

  // count negedges until cs_n low; j=0 is the negedge after the accepting edge
  task automatic wait_fall(output int j);
    j = 0;
    while (cs_n && j < 400) begin
      @(negedge clk);
      j++;
    end
  endtask

  function automatic int slot_evt(input int s, input int slot[8], input bit ena[8]);
    for (int e = 0; e < 8; e++) if (slot[e] == s && ena[e]) return e;
    return -1;
  endfunction

  initial begin
    int j;
    int slot[8];
    bit ena[8];
    int tms[8];
    int expn;
    int tsel;
    logic [15:0] expmask;

    void'($urandom(32'h5eed_0a11));
    idle(3);
    chk(cs_n === 1'b1 && evt_status === 16'h0 && done_flag === 1'b0, "R1 reset state",
        {cs_n, done_flag}, 2);
    rst_n = 1'b1;
    idle(2);
    chk(cs_n === 1'b1 && evt_status === 16'h0 && done_flag === 1'b0, "R1 idle disabled",
        evt_status, 0);

    // R2: enable and trigger together, offset 0
    cfg(0, 0, 1'b1);
    cfg(8, 5, 1'b1);
    @(negedge clk);
    en = 1'b1; trig = 2'b01;
    @(negedge clk);
    trig = '0;
    j = 0;
    wait_fall(j);
    chk(j == 3, "R2 warm-up delay", j, 3);
    chk(cs_evt == 4'd0, "R4 index timer0 ev0", cs_evt, 0);
    idle(30);
    chk(evt_status == 16'h0001, "R6 status after frame", evt_status, 1);
    chk(done_flag == 1'b1, "R7 flag with other timer untriggered", done_flag, 1);

    // R6: write-1-to-clear
    @(negedge clk); st_w1c = 16'h0001;
    @(negedge clk); st_w1c = '0;
    chk(evt_status == 16'h0, "R6 w1c", evt_status, 0);
    chk(done_flag == 1'b1, "R6 flag unaffected by w1c", done_flag, 1);

    // R3 and R8 on timer 1
    fire(2'b10);
    chk(done_flag == 1'b0, "R8 trigger clears flag", done_flag, 0);
    wait_fall(j);
    chk(j == 6, "R3 offset 5 timing", j, 6);
    chk(cs_evt == 4'd8, "R4 index timer1 ev0", cs_evt, 8);
    idle(30);
    chk(evt_status == 16'h0100 && done_flag, "R7 timer1 done", evt_status, 16'h0100);
    fire(2'b10);
    chk(evt_status[8] == 1'b0, "R8 retrigger clears timer status", evt_status, 0);
    idle(30);

    // R5: collision across timers at the same offset
    cfg_clear_all();
    cfg(3, 10, 1'b1);
    cfg(9, 10, 1'b1);
    @(negedge clk); st_w1c = '1;
    @(negedge clk); st_w1c = '0;
    n_log = 0;
    fire(2'b11);
    idle(60);
    chk(n_log == 2, "R5 collision count", n_log, 2);
    chk(log_idx[0] == 3 && log_idx[1] == 9, "R5 lowest index first",
        log_idx[0] * 16 + log_idx[1], 3 * 16 + 9);
    chk(evt_status == 16'h0208, "R5 delayed event served", evt_status, 16'h0208);

    // R9: retrigger mid schedule
    cfg_clear_all();
    cfg(0, 100, 1'b1);
    fire(2'b01);
    j = 0;
    while (cs_n && j < 400) begin
      @(negedge clk);
      j++;
      if (j == 50) trig = 2'b01;
      if (j == 51) trig = 2'b00;
    end
    chk(j == 101, "R9 retrigger ignored", j, 101);
    idle(30);

    // R5, R10: random schedules
    for (int it = 0; it < 6; it++) begin
      tsel = it % 2;
      for (int e = 0; e < 8; e++) slot[e] = e;
      for (int e = 7; e > 0; e--) begin
        int k;
        int tmp;
        k = int'($urandom % (e + 1));
        tmp = slot[e]; slot[e] = slot[k]; slot[k] = tmp;
      end
      expmask = '0;
      cfg_clear_all();
      for (int e = 0; e < 8; e++) begin
        ena[e] = bit'($urandom % 4 != 0);
        tms[e] = slot[e] * 24 + int'($urandom % 4);
        cfg(tsel * 8 + e, tms[e], ena[e]);
        if (ena[e]) expmask[tsel * 8 + e] = 1'b1;
      end
      @(negedge clk); st_w1c = '1;
      @(negedge clk); st_w1c = '0;
      n_log = 0;
      fire(tsel == 0 ? 2'b01 : 2'b10);
      idle(240);
      expn = 0;
      for (int s = 0; s < 8; s++) begin
        int ev;
        ev = slot_evt(s, slot, ena);
        if (ev >= 0) begin
          chk(n_log > expn && log_idx[expn] == tsel * 8 + ev, "R5 ascending order",
              log_idx[expn], tsel * 8 + ev);
          expn++;
        end
      end
      chk(n_log == expn, "R10 disabled events silent", n_log, expn);
      chk(evt_status == expmask, "R10 status matches enables", evt_status, expmask);
      chk(done_flag == 1'b1, "R7 random done", done_flag, 1);
    end

    // R11: disable mid frame
    cfg_clear_all();
    cfg(0, 2, 1'b1);
    cfg(1, 40, 1'b1);
    fire(2'b01);
    idle(8);
    chk(cs_n == 1'b0, "R11 frame active before disable", cs_n, 0);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1 && evt_status == 16'h0 && done_flag == 1'b0, "R11 disable clears",
        {cs_n, done_flag}, 2);
    idle(60);
    chk(cs_n == 1'b1, "R11 timers stopped", cs_n, 1);
    en = 1'b1;
    idle(5);
    fire(2'b01);
    wait_fall(j);
    chk(j == 3, "R3 after re-enable", j, 3);
    idle(80);
    chk(evt_status == 16'h0003 && done_flag, "R7 after re-enable", evt_status, 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule